// File: doc/BRIEF.md
# Colour Lookup Table with Streamed Host Loading

This block holds a colour lookup table of 256 entries, each made of an 8-bit red, green and blue component. A host loads it through two byte offsets. A write to the index register chooses the entry to fill next. Writes to the colour data register then supply components one at a time: red first, then green, then blue. After each full triplet the index moves on to the next entry by itself. Each data write carries either one component or four.

A separate lookup port serves scan-out. Each cycle it takes an 8-bit pixel value and, one cycle later, returns the 24-bit colour stored for it. Each data write also raises a single-cycle refresh hint. The display side uses this hint to redraw everything, because a palette change alters every pixel on screen.

The component position (red, green or blue) is shared by all writes. It is not tied to a write. A four-component write may therefore finish one entry and start the next, and later writes continue from where it stopped.

Top module: `clut_write_port`

## Requirements
- R1: After reset every red, green and blue entry reads back as zero on the lookup port, and the component position is red.
- R2: A write with `addr` = 3'h0 loads the entry index from `wdata[7:0]` and returns the component position to red, even in the middle of a triplet.
- R3: A write with `addr` = 3'h4 and `wr_word` = 0 supplies one component, taken from `wdata[7:0]`. It is stored in the current entry at the current position, and positions advance red, then green, then blue.
- R4: A write with `addr` = 3'h4 and `wr_word` = 1 supplies four components in this order: `wdata[31:24]`, `wdata[23:16]`, `wdata[15:8]`, `wdata[7:0]`.
- R5: Storing a blue component increments the index by one, with 255 wrapping to 0, and returns the position to red.
- R6: The component position persists between writes. A triplet may be split across two four-component writes, and a one-component write after a four-component write continues the same sequence.
- R7: `rdata` reads as zero at all times, whatever has been written.
- R8: `pix_rgb` shows {red, green, blue} of the entry `pix_idx` selected at the previous rising edge, with red in bits 23:16 and blue in bits 7:0.
- R9: `pal_changed` is high for exactly the cycle after each data write. A write to the index register does not raise it.
- R10: A lookup of an entry in the same cycle as a write to that entry returns the value held before the write. The next lookup returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_word | input | 1 | 1: four-component write, 0: one-component write |
| addr | input | 3 | Byte offset: 0x0 index, 0x4 colour data |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Registered colour for the previous `pix_idx` |
| pal_changed | output | 1 | One-cycle refresh hint after a data write |

## Verification
The host write port and the scan-out lookup can touch the same palette entry on the same clock edge. The bench provokes this by driving a one-component data write and a `pix_idx` for the entry being written in the same cycle. It then expects the old colour on `pix_rgb` in the next cycle and the new colour one cycle after that. In the same cycle it also checks that the refresh hint rises together with that collision.

// File: rtl/clut_pkg.sv
package clut_pkg;

   // Position of the next component inside a palette triplet
   typedef enum logic [1:0] {
      C_RED = 2'd0,
      C_GRN = 2'd1,
      C_BLU = 2'd2
   } comp_e;

   localparam int REG_ADDR_W = 3;
   localparam logic [REG_ADDR_W-1:0] OFS_INDEX = 3'h0;
   localparam logic [REG_ADDR_W-1:0] OFS_DATA  = 3'h4;

   function automatic comp_e comp_next(input comp_e c);
      case (c)
         C_RED:   return C_GRN;
         C_GRN:   return C_BLU;
         default: return C_RED;
      endcase
   endfunction

endpackage

// File: rtl/clut_unpack.sv
module clut_unpack #(
   parameter int BUS_W  = 32,
   parameter int COMP_W = 8,
   localparam int NLANES = BUS_W / COMP_W
) (
   input  logic                           word_mode,
   input  logic [BUS_W-1:0]               data,
   output logic [NLANES-1:0][COMP_W-1:0]  lane_data,
   output logic [NLANES-1:0]              lane_vld
);

   // Lane 0 is always the first component applied; in word mode it is
   // the most significant component, otherwise the least significant one.
   for (genvar k = 0; k < NLANES; k++) begin : g_lane
      if (k == 0) begin : g_first
         assign lane_data[k] = word_mode ? data[BUS_W-1 -: COMP_W]
                                         : data[COMP_W-1:0];
         assign lane_vld[k]  = 1'b1;
      end else begin : g_rest
         assign lane_data[k] = data[BUS_W-1-k*COMP_W -: COMP_W];
         assign lane_vld[k]  = word_mode;
      end
   end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int NLANES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          idx_wr,
   input  logic [IDX_W-1:0]              idx_val,
   input  logic                          dat_wr,
   input  logic [NLANES-1:0]             lane_vld,
   output logic [NLANES-1:0]             lane_en,
   output logic [NLANES-1:0][1:0]        lane_comp,
   output logic [NLANES-1:0][IDX_W-1:0]  lane_idx
);

   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

   comp_e            state;
   logic [IDX_W-1:0] idx;

   comp_e            chain_c [NLANES+1];
   logic [IDX_W-1:0] chain_i [NLANES+1];

   // Walk the lanes in order, carrying component position and index
   always_comb begin
      chain_c[0] = state;
      chain_i[0] = idx;
      for (int k = 0; k < NLANES; k++) begin
         lane_en[k]   = dat_wr && lane_vld[k];
         lane_comp[k] = chain_c[k];
         lane_idx[k]  = chain_i[k];
         if (lane_vld[k]) begin
            chain_c[k+1] = comp_next(chain_c[k]);
            chain_i[k+1] = (chain_c[k] == C_BLU) ? chain_i[k] + ONE : chain_i[k];
         end else begin
            chain_c[k+1] = chain_c[k];
            chain_i[k+1] = chain_i[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= C_RED;
         idx   <= '0;
      end else if (idx_wr) begin
         state <= C_RED;
         idx   <= idx_val;
      end else if (dat_wr) begin
         state <= chain_c[NLANES];
         idx   <= chain_i[NLANES];
      end
   end

   assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (state == C_RED && idx == $past(idx_val)));

   assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      logic'(state != C_RED) |-> (state == C_GRN || state == C_BLU));

   assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !idx_wr && lane_vld == NLANES'(1) && state == C_BLU)
      |=> (idx == $past(idx) + ONE && state == C_RED));

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
   parameter int         IDX_W  = 8,
   parameter int         COMP_W = 8,
   parameter int         NLANES = 4,
   parameter logic [1:0] SEL    = 2'd0,
   localparam int        DEPTH  = 1 << IDX_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NLANES-1:0]             lane_en,
   input  logic [NLANES-1:0][1:0]        lane_comp,
   input  logic [NLANES-1:0][IDX_W-1:0]  lane_idx,
   input  logic [NLANES-1:0][COMP_W-1:0] lane_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [COMP_W-1:0]             rd_data
);

   logic [COMP_W-1:0] mem [DEPTH];

   // Read samples the array before this edge's writes land
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= mem[rd_idx];
         for (int k = 0; k < NLANES; k++) begin
            if (lane_en[k] && lane_comp[k] == SEL) mem[lane_idx[k]] <= lane_data[k];
         end
      end
   end

   assert_lane0_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[0] && lane_comp[0] == SEL)
      |=> mem[$past(lane_idx[0])] == $past(lane_data[0]));

endmodule

// File: rtl/clut_write_port.sv
module clut_write_port
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int BUS_W  = 32,
   localparam int NLANES = BUS_W / COMP_W,
   localparam int RGB_W  = 3 * COMP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_word,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]      wdata,
   output logic [BUS_W-1:0]      rdata,
   input  logic [IDX_W-1:0]      pix_idx,
   output logic [RGB_W-1:0]      pix_rgb,
   output logic                  pal_changed
);

   if (BUS_W % COMP_W != 0) begin : g_bad_lanes
      $error("BUS_W must be a multiple of COMP_W");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("IDX_W out of supported range");
   end
   if (IDX_W > BUS_W) begin : g_bad_idx_bus
      $error("index must fit in the host data bus");
   end

   logic idx_wr;
   logic dat_wr;
   assign idx_wr = wr_en && (addr == OFS_INDEX);
   assign dat_wr = wr_en && (addr == OFS_DATA);

   assign rdata = '0;

   logic [NLANES-1:0][COMP_W-1:0] lane_data;
   logic [NLANES-1:0]             lane_vld;
   logic [NLANES-1:0]             lane_en;
   logic [NLANES-1:0][1:0]        lane_comp;
   logic [NLANES-1:0][IDX_W-1:0]  lane_idx;

   clut_unpack #(.BUS_W(BUS_W), .COMP_W(COMP_W)) u_unpack (
      .word_mode (wr_word),
      .data      (wdata),
      .lane_data (lane_data),
      .lane_vld  (lane_vld)
   );

   clut_seq #(.IDX_W(IDX_W), .NLANES(NLANES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .idx_val   (wdata[IDX_W-1:0]),
      .dat_wr    (dat_wr),
      .lane_vld  (lane_vld),
      .lane_en   (lane_en),
      .lane_comp (lane_comp),
      .lane_idx  (lane_idx)
   );

   // One bank per colour; bank c holds component c, red at the top
   for (genvar c = 0; c < 3; c++) begin : g_bank
      clut_bank #(
         .IDX_W(IDX_W), .COMP_W(COMP_W), .NLANES(NLANES), .SEL(2'(c))
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .lane_en   (lane_en),
         .lane_comp (lane_comp),
         .lane_idx  (lane_idx),
         .lane_data (lane_data),
         .rd_idx    (pix_idx),
         .rd_data   (pix_rgb[RGB_W-1-c*COMP_W -: COMP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pal_changed <= 1'b0;
      else        pal_changed <= dat_wr;
   end

   assert_hint_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> pal_changed);

   assert_hint_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> !pal_changed);

endmodule

// File: tb/clut_write_port_bench.sv
module clut_write_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_word = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;
   logic        pal_changed;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] mr [256];
   logic [7:0] mg [256];
   logic [7:0] mb [256];
   logic [7:0] midx;
   int         mst;

   always #4 clk = ~clk;

   clut_write_port u_clut_write_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx),
      .pix_rgb(pix_rgb), .pal_changed(pal_changed)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_store(input logic [7:0] v);
      case (mst)
         0: mr[midx] = v;
         1: mg[midx] = v;
         default: begin mb[midx] = v; midx = midx + 8'd1; end
      endcase
      mst = (mst + 1) % 3;
   endtask

   task automatic model_write(input logic [2:0] a, input logic [31:0] d, input logic w);
      if (a == 3'h0) begin
         midx = d[7:0];
         mst  = 0;
      end else if (a == 3'h4) begin
         if (w) for (int k = 0; k < 4; k++) model_store(d[31-8*k -: 8]);
         else   model_store(d[7:0]);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic w);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; wr_word = w;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d, w);
   endtask

   task automatic lookup_chk(input logic [7:0] p, input string tag);
      logic [23:0] exp;
      @(negedge clk);
      pix_idx = p;
      @(negedge clk);
      exp = {mr[p], mg[p], mb[p]};
      check(pix_rgb === exp, tag, 32'(pix_rgb), 32'(exp));
   endtask

   task automatic t_reset;
      lookup_chk(8'h00, "R1 reset entry 00");
      lookup_chk(8'hFF, "R1 reset entry FF");
      lookup_chk(8'h5A, "R1 reset entry 5A");
      check(pal_changed === 1'b0, "R9 idle after reset", 32'(pal_changed), 0);
      check(rdata === 32'h0, "R7 rdata after reset", rdata, 0);
   endtask

   task automatic t_bytes;
      bus_write(3'h0, 32'h10, 1'b0);
      bus_write(3'h4, 32'hFFFF_FF11, 1'b0);
      bus_write(3'h4, 32'h22, 1'b0);
      bus_write(3'h4, 32'h33, 1'b0);
      bus_write(3'h4, 32'h44, 1'b0);
      lookup_chk(8'h10, "R3 byte triplet entry 10");
      check(pix_rgb === 24'h112233, "R8 bit order entry 10", 32'(pix_rgb), 32'h112233);
      lookup_chk(8'h11, "R5 next entry after blue");
      check(pix_rgb === 24'h440000, "R5 red of entry 11", 32'(pix_rgb), 32'h440000);
      check(rdata === 32'h0, "R7 rdata after data writes", rdata, 0);
   endtask

   task automatic t_words;
      bus_write(3'h0, 32'h20, 1'b0);
      bus_write(3'h4, 32'hA1B2C3D4, 1'b1);
      lookup_chk(8'h20, "R4 word lanes entry 20");
      check(pix_rgb === 24'hA1B2C3, "R4 msb first entry 20", 32'(pix_rgb), 32'hA1B2C3);
      bus_write(3'h4, 32'hE5F60718, 1'b1);
      lookup_chk(8'h21, "R6 straddled entry 21");
      check(pix_rgb === 24'hD4E5F6, "R6 straddle entry 21", 32'(pix_rgb), 32'hD4E5F6);
      bus_write(3'h4, 32'h99, 1'b0);
      lookup_chk(8'h22, "R6 byte after word entry 22");
      check(pix_rgb === 24'h071899, "R6 byte continues entry 22", 32'(pix_rgb), 32'h071899);
      bus_write(3'h4, 32'h55, 1'b0);
      lookup_chk(8'h23, "R6 red of entry 23");
   endtask

   task automatic t_wrap;
      bus_write(3'h0, 32'hFF, 1'b0);
      bus_write(3'h4, 32'h01020304, 1'b1);
      lookup_chk(8'hFF, "R5 entry FF before wrap");
      lookup_chk(8'h00, "R5 wrap to entry 00");
      check(pix_rgb === 24'h040000, "R5 wrapped red", 32'(pix_rgb), 32'h040000);
   endtask

   task automatic t_index_restart;
      bus_write(3'h0, 32'h40, 1'b0);
      bus_write(3'h4, 32'h77, 1'b0);
      bus_write(3'h4, 32'h78, 1'b0);
      bus_write(3'h0, 32'h40, 1'b0);
      bus_write(3'h4, 32'h88, 1'b0);
      bus_write(3'h4, 32'h99, 1'b0);
      bus_write(3'h4, 32'hAA, 1'b0);
      lookup_chk(8'h40, "R2 index write restarts at red");
      check(pix_rgb === 24'h8899AA, "R2 restart entry 40", 32'(pix_rgb), 32'h8899AA);
      lookup_chk(8'h41, "R2 entry 41 untouched");
   endtask

   task automatic t_hint;
      @(negedge clk);
      wr_en = 1'b1; addr = 3'h4; wdata = 32'h5; wr_word = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(3'h4, 32'h5, 1'b0);
      check(pal_changed === 1'b1, "R9 hint after data write", 32'(pal_changed), 1);
      @(negedge clk);
      check(pal_changed === 1'b0, "R9 hint lasts one cycle", 32'(pal_changed), 0);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'h0; wdata = 32'h70; wr_word = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(3'h0, 32'h70, 1'b0);
      check(pal_changed === 1'b0, "R9 no hint for index write", 32'(pal_changed), 0);
   endtask

   task automatic t_collide;
      logic [23:0] old_v;
      bus_write(3'h0, 32'h60, 1'b0);
      bus_write(3'h4, 32'h11, 1'b0);
      bus_write(3'h4, 32'h22, 1'b0);
      bus_write(3'h4, 32'h33, 1'b0);
      bus_write(3'h0, 32'h60, 1'b0);
      old_v = {mr[8'h60], mg[8'h60], mb[8'h60]};
      @(negedge clk);
      wr_en = 1'b1; addr = 3'h4; wdata = 32'hFE; wr_word = 1'b0;
      pix_idx = 8'h60;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(3'h4, 32'hFE, 1'b0);
      check(pix_rgb === old_v, "R10 same-cycle lookup sees old", 32'(pix_rgb), 32'(old_v));
      check(pal_changed === 1'b1, "R9 hint during collision", 32'(pal_changed), 1);
      @(negedge clk);
      check(pix_rgb === 24'hFE2233, "R10 next lookup sees new", 32'(pix_rgb), 32'hFE2233);
   endtask

   initial begin
      for (int e = 0; e < 256; e++) begin mr[e] = 0; mg[e] = 0; mb[e] = 0; end
      midx = 0; mst = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bytes();
      t_words();
      t_wrap();
      t_index_restart();
      t_hint();
      t_collide();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule